// File: doc/BRIEF.md
# Paged Address Translation Table

The block maps addresses arriving on a memory-mapped slave port onto a 64-bit address for a PCI-style master. The incoming address space is cut into equal pages. The address bits above the page offset choose one table entry. The page offset bits pass straight through. The chosen entry supplies every translated bit above the offset, together with a 2-bit address-space code that a neighbouring block decodes. The lookup is purely combinational, so a request can be translated in the same cycle it is presented.

Software programs the table through a 32-bit register window that is addressed by word. Each entry owns two consecutive words: a low word and a high word. Bits that cannot hold data are hard-wired to zero and ignore writes. This covers page-offset positions inside the low word, the whole high word when the target bus is only 32 bits wide, and every word of an entry beyond the configured page count. Because these bits read back as zero, software can discover the configuration by writing ones and reading back.

Top module: `addr_xlate_table`

## Requirements
- R1: After reset every table bit is 0. Reads of any word return 0, and a lookup returns only the incoming offset bits with space code 0.
- R2: The window is word addressed. Entry n owns word 2n (low word) and word 2n+1 (high word). In the low word, bits 1:0 hold the space code and bits 31:2 hold translated address bits 31:2. The high word holds translated address bits 63:32.
- R3: With P = log2(PAGE_SIZE) pass-through bits, low-word bits P-1 down to 2 ignore writes and always read 0. Bits 1:0 and bits 31 down to P are writable.
- R4: Each of the four byte enables (bit b covering data bits 8b+7:8b) controls whether that byte of the addressed word is updated. Bytes whose enable is 0 keep their old value.
- R5: Words whose entry index is NUM_PAGES or above complete normally. Writes to them have no effect and reads of them return 0.
- R6: With BUS64 = 0, high words ignore writes and read 0, and bits 63:32 of every lookup result are 0.
- R7: Read data is registered. It shows the addressed word in the cycle after cfgRdEn is sampled high, and it holds its value while cfgRdEn is low.
- R8: The lookup index is (lkAddrIn >> P) modulo NUM_PAGES. The result is the indexed entry's address bits 63:P joined with lkAddrIn bits P-1:0. lkSpace is that entry's bits 1:0. The output is combinational.
- R9: A write takes effect on the clock edge that samples cfgWrEn high. The lookup output reflects the new value right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWordAddr | input | 10 | Word index inside the table window |
| cfgWrEn | input | 1 | Write strobe |
| cfgByteEn | input | 4 | Byte enables for the write |
| cfgWrData | input | 32 | Write data |
| cfgRdEn | input | 1 | Read strobe |
| cfgRdData | output | 32 | Registered read data |
| lkAddrIn | input | IN_AW | Incoming slave-side address |
| lkAddrOut | output | 64 | Translated master-side address |
| lkSpace | output | 2 | Address-space code of the selected entry |

## Verification
Read data is due one clock after the edge that samples cfgRdEn. A write is visible in storage, and so at the lookup port, right after the edge that samples cfgWrEn. The lookup itself has zero latency. The bench drives inputs on the falling edge. It samples read data on the falling edge that follows the capturing rising edge. It samples lookup results on the falling edge straight after the committing write edge, or a nanosecond after changing lkAddrIn with no edge in between. A hold check leaves cfgRdEn low across a write and confirms the read data has not moved.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
  localparam int MAX_PAGES = 512;
  localparam int ENTRY_W = $clog2(MAX_PAGES);

  // Decoded strobes from control to datapath
  typedef struct packed {
    logic               wrEn;
    logic               rdEn;
    logic               hiWord;
    logic               present;
    logic [ENTRY_W-1:0] entry;
    logic [3:0]         byteEn;
  } xlateStrobes_t;
endpackage

// File: rtl/addr_xlate_ctrl.sv
module addr_xlate_ctrl
  import addr_xlate_pkg::*;
#(
  parameter int NUM_PAGES = 4
) (
  input  logic [9:0]    cfgWordAddr,
  input  logic          cfgWrEn,
  input  logic          cfgRdEn,
  input  logic [3:0]    cfgByteEn,
  output xlateStrobes_t strobes
);
  logic [ENTRY_W-1:0] entryIdx;

  assign entryIdx = cfgWordAddr[9:1];

  always_comb begin
    strobes.wrEn    = cfgWrEn;
    strobes.rdEn    = cfgRdEn;
    strobes.hiWord  = cfgWordAddr[0];
    strobes.present = (32'(entryIdx) < NUM_PAGES);
    strobes.entry   = entryIdx;
    strobes.byteEn  = cfgByteEn;
  end
endmodule

// File: rtl/addr_xlate_datapath.sv
module addr_xlate_datapath
  import addr_xlate_pkg::*;
#(
  parameter int PAGE_SIZE = 4096,
  parameter int NUM_PAGES = 4,
  parameter bit BUS64     = 1'b1,
  parameter int IN_AW     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  xlateStrobes_t    strobes,
  input  logic [31:0]      cfgWrData,
  output logic [31:0]      cfgRdData,
  input  logic [IN_AW-1:0] lkAddrIn,
  output logic [63:0]      lkAddrOut,
  output logic [1:0]       lkSpace
);
  localparam int PASS_BITS = $clog2(PAGE_SIZE);
  localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam logic [63:0] ADDR_KEEP = ~((64'd1 << PASS_BITS) - 64'd1);
  localparam logic [31:0] LO_MASK = {ADDR_KEEP[31:2], 2'b11};
  localparam logic [31:0] HI_MASK = ADDR_KEEP[63:32];

  logic [31:0] loMem [NUM_PAGES];
  logic [31:0] hiMem [NUM_PAGES];
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] lkIdx;
  logic [IN_AW-1:0] pageNum;
  logic [63:0] entryAddr;
  logic doWrite;

  assign wrIdx   = IDX_W'(strobes.entry);
  assign doWrite = strobes.wrEn && strobes.present;

  // Low words always exist
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_PAGES; e++) loMem[e] <= '0;
    end else if (doWrite && !strobes.hiWord) begin
      for (int b = 0; b < 4; b++)
        if (strobes.byteEn[b])
          loMem[wrIdx][b*8 +: 8] <= cfgWrData[b*8 +: 8] & LO_MASK[b*8 +: 8];
    end
  end

  // High words only for a 64-bit target
  generate
    if (BUS64) begin : gHiStore
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int e = 0; e < NUM_PAGES; e++) hiMem[e] <= '0;
        end else if (doWrite && strobes.hiWord) begin
          for (int b = 0; b < 4; b++)
            if (strobes.byteEn[b])
              hiMem[wrIdx][b*8 +: 8] <= cfgWrData[b*8 +: 8] & HI_MASK[b*8 +: 8];
        end
      end
    end else begin : gHiZero
      always_comb begin
        for (int e = 0; e < NUM_PAGES; e++) hiMem[e] = '0;
      end
    end
  endgenerate

  // Registered read-back
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgRdData <= '0;
    end else if (strobes.rdEn) begin
      if (!strobes.present)    cfgRdData <= '0;
      else if (strobes.hiWord) cfgRdData <= hiMem[wrIdx];
      else                     cfgRdData <= loMem[wrIdx];
    end
  end

  // Combinational lookup
  assign pageNum   = lkAddrIn >> PASS_BITS;
  assign lkIdx     = IDX_W'(pageNum % NUM_PAGES);
  assign entryAddr = {hiMem[lkIdx], loMem[lkIdx]};
  assign lkAddrOut = (entryAddr & ADDR_KEEP) | (64'(lkAddrIn) & ~ADDR_KEEP);
  assign lkSpace   = loMem[lkIdx][1:0];
endmodule

// File: rtl/addr_xlate_table.sv
module addr_xlate_table
  import addr_xlate_pkg::*;
#(
  parameter int PAGE_SIZE = 4096,
  parameter int NUM_PAGES = 4,
  parameter bit BUS64     = 1'b1,
  parameter int IN_AW     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [9:0]       cfgWordAddr,
  input  logic             cfgWrEn,
  input  logic [3:0]       cfgByteEn,
  input  logic [31:0]      cfgWrData,
  input  logic             cfgRdEn,
  output logic [31:0]      cfgRdData,
  input  logic [IN_AW-1:0] lkAddrIn,
  output logic [63:0]      lkAddrOut,
  output logic [1:0]       lkSpace
);
  xlateStrobes_t strobes;

  addr_xlate_ctrl #(.NUM_PAGES(NUM_PAGES)) ctrl (
    .cfgWordAddr(cfgWordAddr),
    .cfgWrEn    (cfgWrEn),
    .cfgRdEn    (cfgRdEn),
    .cfgByteEn  (cfgByteEn),
    .strobes    (strobes)
  );

  addr_xlate_datapath #(
    .PAGE_SIZE(PAGE_SIZE),
    .NUM_PAGES(NUM_PAGES),
    .BUS64    (BUS64),
    .IN_AW    (IN_AW)
  ) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .lkAddrIn (lkAddrIn),
    .lkAddrOut(lkAddrOut),
    .lkSpace  (lkSpace)
  );
endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk #(
  parameter int PAGE_SIZE = 4096,
  parameter int NUM_PAGES = 4,
  parameter bit BUS64     = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic [9:0]  cfgWordAddr,
  input logic        cfgRdEn,
  input logic [31:0] cfgRdData,
  input logic [63:0] lkAddrOut
);
  localparam int PASS_BITS = $clog2(PAGE_SIZE);
  localparam logic [63:0] KEEP = ~((64'd1 << PASS_BITS) - 64'd1);
  localparam logic [31:0] LO_FIXED = ~{KEEP[31:2], 2'b11};

  // R3
  lo_pass_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && !cfgWordAddr[0]) |=> ((cfgRdData & LO_FIXED) == 32'd0));

  // R5
  absent_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && (32'(cfgWordAddr[9:1]) >= NUM_PAGES)) |=> (cfgRdData == 32'd0));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdEn |=> $stable(cfgRdData));

  // R6
  narrow_hi_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!BUS64 && cfgRdEn && cfgWordAddr[0]) |=> (cfgRdData == 32'd0));

  // R6
  narrow_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    !BUS64 |-> (lkAddrOut[63:32] == 32'd0));
endmodule

bind addr_xlate_table addr_xlate_chk #(
  .PAGE_SIZE(PAGE_SIZE),
  .NUM_PAGES(NUM_PAGES),
  .BUS64    (BUS64)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWordAddr(cfgWordAddr),
  .cfgRdEn    (cfgRdEn),
  .cfgRdData  (cfgRdData),
  .lkAddrOut  (lkAddrOut)
);

// File: tb/addr_xlate_table_test.sv
`timescale 1ns/1ps
module addr_xlate_table_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  cfgWordAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic        cfgRdEn = 1'b0;
  logic [31:0] cfgRdData, rdData32;
  logic [31:0] lkAddrIn = '0;
  logic [63:0] lkAddrOut, lkAddrOut32;
  logic [1:0]  lkSpace, lkSpace32;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_xlate_table uut (
    .clk(clk), .rstN(rstN), .cfgWordAddr(cfgWordAddr), .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdEn(cfgRdEn),
    .cfgRdData(cfgRdData), .lkAddrIn(lkAddrIn), .lkAddrOut(lkAddrOut),
    .lkSpace(lkSpace)
  );

  addr_xlate_table #(.BUS64(1'b0)) uut32 (
    .clk(clk), .rstN(rstN), .cfgWordAddr(cfgWordAddr), .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdEn(cfgRdEn),
    .cfgRdData(rdData32), .lkAddrIn(lkAddrIn), .lkAddrOut(lkAddrOut32),
    .lkSpace(lkSpace32)
  );

  typedef struct packed {
    logic [9:0]  word;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] expRd;
    logic [7:0]  req;
  } vec_t;

  // PAGE_SIZE 4096 -> low-word writable mask 0xFFFFF003
  localparam vec_t VECS [7] = '{
    '{10'h000, 32'hABCDE123, 4'hF, 32'hABCDE003, 8'd3},  // R3 entry 0 low
    '{10'h001, 32'h12345678, 4'hF, 32'h12345678, 8'd2},  // R2 entry 0 high
    '{10'h002, 32'hFFFFFFFF, 4'h3, 32'h0000F003, 8'd4},  // R4 low bytes only
    '{10'h006, 32'h5555A002, 4'hF, 32'h5555A002, 8'd2},  // R2 entry 3 low
    '{10'h007, 32'hDEADBEEF, 4'hC, 32'hDEAD0000, 8'd4},  // R4 high bytes only
    '{10'h008, 32'hFFFFFFFF, 4'hF, 32'h00000000, 8'd5},  // R5 entry 4 absent
    '{10'h3FF, 32'hFFFFFFFF, 4'hF, 32'h00000000, 8'd5}   // R5 last word absent
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [9:0] w, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgWordAddr = w; cfgWrData = d; cfgByteEn = be; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [9:0] w, output logic [31:0] d, output logic [31:0] d32);
    @(negedge clk);
    cfgWordAddr = w; cfgRdEn = 1'b1;
    @(negedge clk);
    cfgRdEn = 1'b0;
    d = cfgRdData; d32 = rdData32;
  endtask

  task automatic lookup(input logic [31:0] a);
    lkAddrIn = a;
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] got, got32;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    doRead(10'h000, got, got32); check(got == 0, "R1", 64'(got), 0);
    doRead(10'h001, got, got32); check(got == 0, "R1", 64'(got), 0);
    doRead(10'h006, got, got32); check(got == 0, "R1", 64'(got), 0);
    lookup(32'h0000_3123);
    check(lkAddrOut == 64'h123 && lkSpace == 0, "R1", lkAddrOut, 64'h123);

    // Vector table: write then read back
    for (int i = 0; i < 7; i++) begin
      doWrite(VECS[i].word, VECS[i].wdata, VECS[i].be);
      doRead(VECS[i].word, got, got32);
      check(got == VECS[i].expRd, $sformatf("R%0d", VECS[i].req), 64'(got), 64'(VECS[i].expRd));
    end

    // R8 lookup with index and pass-through merge
    lookup(32'h0000_0ABC);
    check(lkAddrOut == 64'h12345678_ABCDEABC, "R8", lkAddrOut, 64'h12345678_ABCDEABC);
    check(lkSpace == 2'd3, "R8", 64'(lkSpace), 64'd3);
    lookup(32'h0000_3777);
    check(lkAddrOut == 64'hDEAD0000_5555A777, "R8", lkAddrOut, 64'hDEAD0000_5555A777);
    check(lkSpace == 2'd2, "R8", 64'(lkSpace), 64'd2);
    lookup(32'h0000_4123);  // page 4 wraps to entry 0
    check(lkAddrOut == 64'h12345678_ABCDE123, "R8", lkAddrOut, 64'h12345678_ABCDE123);

    // R9 lookup sees the write right after its edge
    lookup(32'h0000_1005);
    doWrite(10'h002, 32'h11111001, 4'hF);
    check(lkAddrOut == 64'h00000000_11111005 && lkSpace == 2'd1, "R9",
          lkAddrOut, 64'h00000000_11111005);

    // R6 narrow instance
    doRead(10'h001, got, got32);
    check(got32 == 0, "R6", 64'(got32), 0);
    check(got == 32'h12345678, "R2", 64'(got), 64'h12345678);
    lookup(32'h0000_0ABC);
    check(lkAddrOut32 == 64'h00000000_ABCDEABC, "R6", lkAddrOut32, 64'h00000000_ABCDEABC);

    // R7 read data holds while cfgRdEn is low
    doWrite(10'h001, 32'h0F0F0F0F, 4'hF);
    @(negedge clk);
    check(cfgRdData == 32'h12345678, "R7", 64'(cfgRdData), 64'h12345678);
    doRead(10'h001, got, got32);
    check(got == 32'h0F0F0F0F, "R7", 64'(got), 64'h0F0F0F0F);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule